// File: doc/BRIEF.md
# Power-up Reset Generator with Clock-Lock Qualification

This block makes the active-low synchronous reset for the logic that shares its clock. It has no reset input. It relies only on every register starting at zero when the device is configured. A small saturating counter begins at zero and counts clock edges. While the counter is below its all-ones value, the reset output stays asserted. Once the counter reaches all ones it stops, and it never counts again.

When the clock comes from a PLL, the block also waits for the PLL lock indication. The lock input is asynchronous to the generated clock, so it passes through a shift-register synchronizer clocked by that clock. Reset is released only when the counter has finished and the last synchronizer stage is high. If lock is lost later, reset is asserted again as soon as the loss reaches the end of the chain. Reset is released again once lock has travelled back through the chain. A parameter turns the lock check off for designs without a PLL. In that case the lock input has no effect.

Top module: `rstgen_top`

## Requirements
- R1: Before the first clock edge, `rst_n_o` is low, because every register starts at zero.
- R2: The hold counter is `CNT_W` bits wide (default 4) and starts at zero. `rst_n_o` is low whenever the counter is not all ones. With the lock already synchronized, `rst_n_o` is low after clock edges 1 to 14 and first goes high after edge 15.
- R3: On each clock edge the counter increments by exactly one while it is not all ones. Once it is all ones it holds that value for all later edges.
- R4: The lock input passes through `SYNC_STAGES` flip-flops (default 4) clocked by `clk`. If lock is high at edge k, after being low, the synchronized lock is high from edge k+3 on. `rst_n_o` is not released before that edge. Example: lock rises after edge 20, so release comes after edge 24.
- R5: If lock is low at edge k after release, `rst_n_o` stays high after edges k, k+1 and k+2, and it is low after edge k+3.
- R6: After a loss of lock, `rst_n_o` goes high again after edge k+3, where k is the first edge at which lock is high again. The hold counter is not restarted.
- R7: With `USE_LOCK` = 0, the lock input is ignored. `rst_n_o` is released after edge 15 even if the lock input is held low.
- R8: `rst_n_o` changes only at rising clock edges. It keeps the same value throughout each clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the destination domain (the generated clock) |
| pll_lock_i | input | 1 | Asynchronous lock indication; ignored when USE_LOCK = 0 |
| rst_n_o | output | 1 | Active-low reset for downstream logic, changes only at clock edges |

## Verification
A wrong counter state shows up at the port by the end of the first 16 clock edges. If the counter skips a value, release comes early. If it fails to saturate, release comes late, or reset drops again once the counter wraps. A synchronizer with too many or too few stages moves every lock-driven edge of the reset by one cycle per stage. The bench therefore checks the cycle of each edge exactly, at startup, when lock arrives late, when lock is lost and when lock returns. Any error in the number of stages or in the gating condition shows at the first lock transition that follows it.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  // Default width of the hold counter; release after 2**W - 1 edges.
  localparam int unsigned DEF_CNT_W       = 4;
  // Default depth of the lock synchronizer.
  localparam int unsigned DEF_SYNC_STAGES = 4;
endpackage

// File: rtl/rstgen_hold_cnt.sv
module rstgen_hold_cnt #(
  parameter int unsigned CNT_W = rstgen_pkg::DEF_CNT_W
) (
  input  logic             clk,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // Zero is the only start value used, so it is portable across toolflows.
  logic [CNT_W-1:0] cnt_q = '0;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // The counter stops for good once it is all ones.
  assign done_o = &cnt_q;
  assign cnt_en = ~done_o;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk) begin
    cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rstgen_lock_sync.sv
module rstgen_lock_sync #(
  parameter int unsigned SYNC_STAGES = rstgen_pkg::DEF_SYNC_STAGES
) (
  input  logic                   clk,
  input  logic                   lock_async_i,
  output logic [SYNC_STAGES-1:0] chain_o,
  output logic                   lock_sync_o
);
  logic [SYNC_STAGES-1:0] chain_q = '0;
  logic [SYNC_STAGES-1:0] chain_d;

  // Each stage takes the value of the stage before it.
  assign chain_d[0] = lock_async_i;
  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
    assign chain_d[g] = chain_q[g-1];
  end

  always_ff @(posedge clk) begin
    chain_q <= chain_d;
  end

  assign chain_o     = chain_q;
  assign lock_sync_o = chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/rstgen_top.sv
module rstgen_top #(
  parameter int unsigned CNT_W       = rstgen_pkg::DEF_CNT_W,
  parameter int unsigned SYNC_STAGES = rstgen_pkg::DEF_SYNC_STAGES,
  parameter bit          USE_LOCK    = 1'b1
) (
  input  logic clk,
  input  logic pll_lock_i,
  output logic rst_n_o
);
  logic [CNT_W-1:0]       hold_cnt;
  logic                   hold_done;
  logic [SYNC_STAGES-1:0] lock_chain;
  logic                   lock_sync;
  logic                   lock_ok;

  rstgen_hold_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .cnt_o  (hold_cnt),
    .done_o (hold_done)
  );

  rstgen_lock_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk          (clk),
    .lock_async_i (pll_lock_i),
    .chain_o      (lock_chain),
    .lock_sync_o  (lock_sync)
  );

  if (USE_LOCK) begin : g_lock
    assign lock_ok = lock_sync;
  end else begin : g_nolock
    assign lock_ok = 1'b1;
  end

  // Both terms are flip-flop outputs, so the reset changes only at edges.
  assign rst_n_o = hold_done & lock_ok;
endmodule

// File: rtl/rstgen_checker.sv
module rstgen_checker #(
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SYNC_STAGES = 4,
  parameter bit          USE_LOCK    = 1'b1
) (
  input logic                   clk,
  input logic                   pll_lock_i,
  input logic [CNT_W-1:0]       hold_cnt,
  input logic [SYNC_STAGES-1:0] lock_chain,
  input logic                   rst_n_o
);
  logic seen_edge = 1'b0;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  initial begin
    #0 assert (rst_n_o == 1'b0) else $error("reset released at time zero"); // R1
  end

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!seen_edge)
    (hold_cnt != {CNT_W{1'b1}}) |-> !rst_n_o); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!seen_edge)
    (hold_cnt != {CNT_W{1'b1}}) |=> (hold_cnt == $past(hold_cnt) + 1'b1)); // R3

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!seen_edge)
    (hold_cnt == {CNT_W{1'b1}}) |=> $stable(hold_cnt)); // R3

  AST_SYNC_ENTRY: assert property (@(posedge clk) disable iff (!seen_edge)
    1'b1 |=> (lock_chain[0] == $past(pll_lock_i))); // R4

  AST_LOCK_GATE: assert property (@(posedge clk) disable iff (!seen_edge)
    (USE_LOCK && !lock_chain[SYNC_STAGES-1]) |-> !rst_n_o); // R5

  AST_NOLOCK_FREE: assert property (@(posedge clk) disable iff (!seen_edge)
    (!USE_LOCK && hold_cnt == {CNT_W{1'b1}}) |-> rst_n_o); // R7
endmodule

bind rstgen_top rstgen_checker #(
  .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES), .USE_LOCK(USE_LOCK)
) u_chk (
  .clk        (clk),
  .pll_lock_i (pll_lock_i),
  .hold_cnt   (hold_cnt),
  .lock_chain (lock_chain),
  .rst_n_o    (rst_n_o)
);

// File: tb/tb_rstgen_top.sv
`timescale 1ns/1ps
module tb_rstgen_top;
  logic clk = 1'b0;
  logic lock_a = 1'b1;   // locked from time zero
  logic lock_b = 1'b0;   // lock arrives late
  logic lock_c = 1'b0;   // lock unused, held low
  logic rn_a, rn_b, rn_c;
  int   edges = 0;
  int   n_chk = 0;
  int   n_err = 0;

  always #5 clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  rstgen_top #(.USE_LOCK(1'b1)) dut (.clk(clk), .pll_lock_i(lock_a), .rst_n_o(rn_a));
  rstgen_top #(.USE_LOCK(1'b1)) dut_late (.clk(clk), .pll_lock_i(lock_b), .rst_n_o(rn_b));
  rstgen_top #(.USE_LOCK(1'b0)) dut_nolock (.clk(clk), .pll_lock_i(lock_c), .rst_n_o(rn_c));

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s edge=%0d actual=%b expected=%b", req, edges, act, exp);
    end
  endtask

  // R1: all outputs low before any edge.
  task automatic t_time_zero();
    #1;
    check("R1 locked", rn_a, 1'b0);
    check("R1 late", rn_b, 1'b0);
    check("R1 nolock", rn_c, 1'b0);
  endtask

  // R2, R4, R7: startup release timing for the three instances.
  task automatic t_startup();
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check("R2 locked hold", rn_a, (edges >= 15));
      check("R7 nolock hold", rn_c, (edges >= 15));
      check("R4 late lock", rn_b, (edges >= 24));
      if (edges == 20) lock_b = 1'b1;
    end
  endtask

  // R5, R6, R8: loss and return of lock after release.
  task automatic t_drop();
    int k;
    @(negedge clk);
    lock_a = 1'b0;
    k = edges + 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R5 drop", rn_a, (edges < k + 3));
      #3;
      check("R8 mid-cycle", rn_a, (edges < k + 3));
    end
    lock_a = 1'b1;
    k = edges + 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R6 return", rn_a, (edges >= k + 3));
    end
  endtask

  // R7: lock input toggling has no effect when unused.
  task automatic t_nolock_ignore();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      lock_c = ~lock_c;
      check("R7 ignore", rn_c, 1'b1);
    end
  endtask

  initial begin
    fork
      begin
        t_time_zero();
        t_startup();
        t_drop();
        t_nolock_ignore();
      end
      begin
        repeat (2000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule